// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a target-only SMBus/I2C endpoint that owns a file of seven 8-bit control registers. A host reaches it at one fixed 7-bit address. Every transfer names a starting register offset and moves a block of bytes from there, with the offset advancing after each byte. On a write the host supplies an explicit byte count before the data. On a read the target sends a count first and then the register bytes.

SCL and SDA are sampled in the system clock domain through synchronizers. The target pulls SDA low through an open-drain enable output. The register contents are presented on one flat parallel bus, so the surrounding logic can use the control fields directly. Some bits in the file are fixed identification or reserved bits that the bus cannot change. An active-low reset puts every register back to its power-up value.

Top module: `smb_regfile_slave`

## Requirements
- R1: The target answers only to address bits 1101001; the address byte 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and SDA stays released until the next START.
- R2: A write frame has this order: address 0xD2, offset, count N (N ≥ 1), then N data bytes. Every byte is acknowledged, and the data bytes go to consecutive offsets starting at the given offset.
- R3: A write count of 0 is not acknowledged, the frame ends, and no register changes.
- R4: A read frame has this order: 0xD2, offset, repeated START, 0xD3. The target then sends a count byte equal to 7 minus the offset (0 when the offset is above 6), followed by register bytes from the offset upward. A host NACK ends the transmission.
- R5: After reset the registers hold byte0=0x2D, byte1=0x80, byte2=0x00, byte3=0x16 and bytes 4, 5 and 6 = 0x00. Asserting rst_n low at any time restores these values.
- R6: The writable bits are byte0 mask 0xFD, byte1 mask 0x80 and byte3 mask 0xB6. All other bits keep their reset value on writes: reserved bits, the whole of bytes 2, 4 and 6, and the revision/vendor ID nibbles in byte5.
- R7: Offsets above 6 read as 0x00. Writes there are acknowledged but discarded.
- R8: A STOP at any point returns the target to idle with SDA released. A START at any point restarts the address phase.
- R9: Data bytes sent after the N counted ones are not acknowledged and not stored.
- R10: Register byte i appears on regs_o[8*i+7:8*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, reloads defaults |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 8*NREG | Flat register contents, byte i at bits 8i+7:8i |

## Verification
The bench writes each register with all-ones and all-zeros patterns. A wrong write mask would show up as a reserved or ID bit set on regs_o, or as a writable bit that fails to change. Counted writes of zero, of data past the count and of data past offset 6 are each followed by a look at the register outputs and at the ACK bit. A target that accepted these would either corrupt a register or acknowledge a byte it should refuse. Reads are started at offset 0 and at offset 5 and run past the end, to catch a count byte computed from the wrong origin or a pointer that wraps back into real registers. A STOP in the middle of a frame and a reset in the middle of a frame check that neither leaves the state machine holding SDA low or stuck partway through a byte.

// File: rtl/smbrf_pkg.sv
package smbrf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_OFF,
    K_CNT,
    K_DATA
  } rx_kind_e;

  // Power-up value of register idx
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h2D;
      1:       return 8'h80;
      3:       return 8'h16;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of register idx that the bus may change
  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'hFD;
      1:       return 8'h80;
      3:       return 8'hB6;
      default: return 8'h00;
    endcase
  endfunction

  // Count of registers from off up to the last one
  function automatic logic [7:0] avail_count(input logic [7:0] off, input int nreg);
    if (int'(off) < nreg) return 8'(nreg - int'(off));
    return 8'h00;
  endfunction

  // Offset advance, saturating at the top of the byte range
  function automatic logic [7:0] ptr_step(input logic [7:0] p);
    if (p == 8'hFF) return p;
    return p + 8'h01;
  endfunction

endpackage

// File: rtl/smbrf_sync.sv
module smbrf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SDA edges while SCL stays high mark frame boundaries
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smbrf_regbank.sv
module smbrf_regbank
  import smbrf_pkg::*;
#(
  parameter int NREG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [8*NREG-1:0] regs_flat
);

  logic [7:0] q_arr [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] DEF  = reg_default(i);
    localparam logic [7:0] MASK = reg_wmask(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q_arr[i] <= DEF;
      else if (wr_en && wr_addr == 8'(i))
        q_arr[i] <= (q_arr[i] & ~MASK) | (wr_data & MASK);
    end

    assign regs_flat[8*i +: 8] = q_arr[i];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == 8'(i)) rd_data = q_arr[i];
  end

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NREG) |=> $stable(regs_flat))
    else $error("write beyond the file changed a register"); // R7

endmodule

// File: rtl/smbrf_ctrl.sv
module smbrf_ctrl
  import smbrf_pkg::*;
#(
  parameter int         NREG     = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr
);

  smb_state_e state;
  rx_kind_e   kind;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [7:0] ptr;
  logic [7:0] remain;
  logic       is_read;
  logic       host_ack;

  // Named internal events
  logic       byte_done;
  logic       addr_hit;
  logic       ack_now;
  logic [7:0] cnt_byte;

  assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = (sh[7:1] == DEV_ADDR);
  assign cnt_byte  = avail_count(ptr, NREG);

  always_comb begin
    case (kind)
      K_ADDR:  ack_now = addr_hit;
      K_OFF:   ack_now = 1'b1;
      K_CNT:   ack_now = (sh != 8'h00);
      default: ack_now = (remain != 8'h00);
    endcase
  end

  assign wr_en   = byte_done && (kind == K_DATA) && (remain != 8'h00);
  assign wr_addr = ptr;
  assign wr_data = sh;
  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      sh       <= '0;
      ptr      <= '0;
      remain   <= '0;
      is_read  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (ack_now) begin
              sda_oe <= 1'b1;
              state  <= ST_RX_ACK;
              case (kind)
                K_ADDR: is_read <= sh[0];
                K_OFF:  ptr     <= sh;
                K_CNT:  remain  <= sh;
                default: begin
                  remain <= remain - 8'd1;
                  ptr    <= ptr_step(ptr);
                end
              endcase
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            state  <= ST_RX;
            case (kind)
              K_ADDR: begin
                if (is_read) begin
                  state  <= ST_TX;
                  sh     <= cnt_byte;
                  sda_oe <= ~cnt_byte[7];
                end else begin
                  kind <= K_OFF;
                end
              end
              K_OFF:   kind <= K_CNT;
              K_CNT:   kind <= K_DATA;
              default: kind <= K_DATA;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr_step(ptr);
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe)
    else $error("SDA held while idle"); // R1

  AST_ADDR_HIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == K_ADDR && sh[7:1] == DEV_ADDR) |=> sda_oe)
    else $error("own address not acknowledged"); // R1

  AST_ZERO_CNT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == K_CNT && sh == 8'h00) |=> (state == ST_IDLE && !sda_oe))
    else $error("zero count accepted"); // R3

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_oe))
    else $error("STOP did not end the frame"); // R8

endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave
  import smbrf_pkg::*;
#(
  parameter int         NREG        = 7,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [8*NREG-1:0] regs_o
);

  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;

  smbrf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smbrf_ctrl #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr)
  );

  smbrf_regbank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: tb/smb_regfile_slave_tb.sv
module smb_regfile_slave_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [55:0] regs_o;
  wire         sda_line = sda_m & ~sda_oe;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  smb_regfile_slave u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl_m),
    .sda_in (sda_line),
    .sda_oe (sda_oe),
    .regs_o (regs_o)
  );

  // {offset, written byte, expected register value}
  localparam logic [23:0] VEC [10] = '{
    24'h00_FF_FD, 24'h00_00_00, 24'h01_FF_80, 24'h01_00_00, 24'h02_FF_00,
    24'h03_FF_B6, 24'h03_49_00, 24'h04_FF_00, 24'h05_FF_00, 24'h06_FF_00
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(input int i);
    return regs_o[8*i +: 8];
  endfunction

  task automatic wq();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  // Counted write; acks bit k set when byte k of the frame was acknowledged
  task automatic smb_write(input logic [7:0] dev, input logic [7:0] off, input logic [7:0] cnt,
                           input int nd, input logic [7:0] d [8], output logic [11:0] acks);
    logic a;
    acks = '0;
    bus_start();
    send_byte(dev, a); acks[0] = a;
    send_byte(off, a); acks[1] = a;
    send_byte(cnt, a); acks[2] = a;
    for (int k = 0; k < nd; k++) begin
      send_byte(d[k], a); acks[3+k] = a;
    end
    bus_stop();
  endtask

  task automatic smb_read(input logic [7:0] off, input int nd, output logic [7:0] cnt,
                          output logic [7:0] d [8], output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(off, a1);
    bus_start();
    send_byte(8'hD3, a2);
    ok = a0 & a1 & a2;
    recv_byte(1'b1, cnt);
    for (int k = 0; k < nd; k++) recv_byte(k != nd - 1, d[k]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  d [8];
    logic [7:0]  q [8];
    logic [7:0]  cnt;
    logic [11:0] acks;
    logic        ok;
    logic        a;
    for (int k = 0; k < 8; k++) begin d[k] = 8'h00; q[k] = 8'h00; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wq();

    // R5 R10: power-up values on the parallel bus
    chk("R5 b0", rbyte(0), 8'h2D); chk("R5 b1", rbyte(1), 8'h80);
    chk("R5 b3", rbyte(3), 8'h16); chk("R10 b5", rbyte(5), 8'h00);

    // R6: single-byte writes through the mask table
    for (int v = 0; v < 10; v++) begin
      d[0] = VEC[v][15:8];
      smb_write(8'hD2, VEC[v][23:16], 8'd1, 1, d, acks);
      chk("R6 write acks", {4'h0, acks[3:0]}, 8'h0F);
      chk("R6 masked value", rbyte(int'(VEC[v][23:16])), VEC[v][7:0]);
    end

    // R2: four-byte block at offset 0
    d[0] = 8'h12; d[1] = 8'h34; d[2] = 8'h56; d[3] = 8'h78;
    smb_write(8'hD2, 8'h00, 8'd4, 4, d, acks);
    chk("R2 acks", acks[7:0], 8'h7F);
    chk("R2 b0", rbyte(0), 8'h10); chk("R2 b1", rbyte(1), 8'h00);
    chk("R2 b3", rbyte(3), 8'h30);

    // R4: full read from offset 0
    smb_read(8'h00, 7, cnt, q, ok);
    chk("R4 addr acks", {7'h0, ok}, 8'h01);
    chk("R4 count", cnt, 8'h07);
    chk("R4 d0", q[0], 8'h10); chk("R4 d3", q[3], 8'h30); chk("R4 d6", q[6], 8'h00);

    // R4 R7: read from offset 5 running past the end
    smb_read(8'h05, 4, cnt, q, ok);
    chk("R4 count from 5", cnt, 8'h02);
    chk("R7 beyond end", q[3], 8'h00);
    smb_read(8'h09, 1, cnt, q, ok);
    chk("R7 count beyond", cnt, 8'h00);

    // R3: zero count refused, register untouched
    d[0] = 8'hFF;
    smb_write(8'hD2, 8'h00, 8'd0, 1, d, acks);
    chk("R3 count nack", {5'h0, acks[2:0]}, 8'h03);
    chk("R3 data nack", {7'h0, acks[3]}, 8'h00);
    chk("R3 b0 kept", rbyte(0), 8'h10);

    // R1: foreign address ignored through the whole frame
    smb_write(8'hA4, 8'h00, 8'd1, 1, d, acks);
    chk("R1 foreign", {4'h0, acks[3:0]}, 8'h00);
    chk("R1 b0 kept", rbyte(0), 8'h10);

    // R9: byte after the counted one refused
    d[0] = 8'hFF; d[1] = 8'h00;
    smb_write(8'hD2, 8'h03, 8'd1, 2, d, acks);
    chk("R9 acks", {3'h0, acks[4:0]}, 8'h0F);
    chk("R9 b3", rbyte(3), 8'hB6);

    // R7: writes past offset 6 acknowledged and dropped
    d[0] = 8'hFF; d[1] = 8'hFF; d[2] = 8'hFF;
    smb_write(8'hD2, 8'h05, 8'd3, 3, d, acks);
    chk("R7 acks", {2'h0, acks[5:0]}, 8'h3F);
    chk("R7 b6", rbyte(6), 8'h00);

    // R8: STOP mid-frame, then a normal write
    bus_start(); send_byte(8'hD2, a); bus_stop();
    chk("R8 released", {7'h0, sda_oe}, 8'h00);
    d[0] = 8'h04;
    smb_write(8'hD2, 8'h00, 8'd1, 1, d, acks);
    chk("R8 after abort", rbyte(0), 8'h04);

    // R5: reset in the middle of a frame
    bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a);
    @(negedge clk); rst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R5 reload b0", rbyte(0), 8'h2D);
    chk("R5 reload b3", rbyte(3), 8'h16);
    rst_n = 1'b1; bus_stop();
    chk("R5 released", {7'h0, sda_oe}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule